// File: doc/BRIEF.md
# Paged Fetch Address Generator with Return Stack

This block produces the instruction fetch address for a small processor whose program store holds 2048 words of 12 bits. An 11-bit counter register drives the fetch address and normally steps forward by one each clock. It runs through 512-word page boundaries without any special handling, and it wraps from the last address back to zero. The decoder raises jump, call and return requests. Branch targets are built from low address bits carried in the instruction, placed under page-select bits taken from a status register that sits outside the block.

An eight-entry return stack stores the address after each call and restores it on a return. The data path cannot read or write this stack. The low byte of the counter is also mapped into the data space as a readable register. Writing that register acts as a computed jump. When a push would exceed the depth, or a pop finds the stack empty, a sticky fault flag is set for test. A stall input freezes the counter and the stack.

Top module: `fetch_pc_unit`

## Requirements
- R1: While `rst` is sampled high on a rising edge, the next value of `fetch_addr` is 0x7FF, `stack_fault` is 0 and the stack is emptied. Every stack slot reads as 0x000 until it is first written.
- R2: When no request is active and `stall` is low, `fetch_addr` increases by one on the next edge. It wraps from 0x7FF to 0x000 and crosses 512-word page boundaries (for example 0x1FF to 0x200) unchanged.
- R3: A jump loads `{page_sel[1:0], imm_addr[8:0]}`. Bit 2 of `page_sel` has no effect on any target, because the address space is 2K words.
- R4: A call loads `{page_sel[1:0], 1'b0, imm_addr[7:0]}` and pushes `fetch_addr + 1` (modulo 2048) onto the return stack.
- R5: A return loads the most recently pushed address that has not yet been popped. Up to eight nested calls return in LIFO order.
- R6: `pcl_rdata` always equals bits 7:0 of `fetch_addr`.
- R7: A write of the low-byte register (`pcl_we`) loads `{page_sel[1:0], 1'b0, pcl_wdata}`.
- R8: When several requests are asserted together, return wins over call, call over jump, and jump over a low-byte write. Only the winning request changes the counter or the stack.
- R9: While `stall` is high, `fetch_addr`, the stack and `stack_fault` keep their values, and all requests in that cycle are ignored.
- R10: A call made while eight entries are held discards the oldest entry, keeps the newest eight, and sets `stack_fault`.
- R11: A return made on an empty stack loads the address most recently popped (0x000 if nothing has been popped or written since reset), leaves the stack empty, and sets `stack_fault`.
- R12: Once set, `stack_fault` stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Freezes counter and stack for the cycle |
| jump_req | input | 1 | Jump request from the decoder |
| call_req | input | 1 | Call request from the decoder |
| ret_req | input | 1 | Return request from the decoder |
| pcl_we | input | 1 | Data-path write strobe for the low-byte register |
| imm_addr | input | 9 | Target bits carried in the instruction |
| page_sel | input | 3 | Page-select bits from the status register |
| pcl_wdata | input | 8 | Data written to the low-byte register |
| fetch_addr | output | 11 | Registered instruction fetch address |
| pcl_rdata | output | 8 | Low byte of the counter as seen by the data path |
| stack_fault | output | 1 | Sticky overflow/underflow flag |

## Verification
Every result is due exactly one rising edge after the request that causes it is sampled. This holds for the new fetch address, the stack contents seen by a later return, and the setting of the fault flag. The low-byte read port follows the counter in the same cycle. The bench applies inputs one time unit after an edge and advances its queue-based model on the next edge. It compares all three outputs one time unit after that edge, so each comparison falls in the single cycle in which the result first appears.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  // Operation chosen for the counter in a given cycle
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_INC,
    OP_JUMP,
    OP_CALL,
    OP_RET,
    OP_PCW
  } fpc_op_e;

endpackage

// File: rtl/fpc_decide.sv
module fpc_decide
  import fpc_pkg::*;
(
  input  logic    stall,
  input  logic    ret_req,
  input  logic    call_req,
  input  logic    jump_req,
  input  logic    pcl_we,
  output fpc_op_e op
);

  // Fixed priority: stall, return, call, jump, low-byte write, increment
  always_comb begin
    if (stall)         op = OP_HOLD;
    else if (ret_req)  op = OP_RET;
    else if (call_req) op = OP_CALL;
    else if (jump_req) op = OP_JUMP;
    else if (pcl_we)   op = OP_PCW;
    else               op = OP_INC;
  end

endmodule

// File: rtl/fpc_target.sv
module fpc_target
  import fpc_pkg::*;
#(
  parameter int AW = 11,
  parameter int PW = 3,
  parameter int JW = 9,
  parameter int CW = 8
) (
  input  fpc_op_e         op,
  input  logic [AW-1:0]   pc_q,
  input  logic [PW-1:0]   page,
  input  logic [JW-1:0]   imm,
  input  logic [CW-1:0]   wdata,
  input  logic [AW-1:0]   pop_addr,
  output logic [AW-1:0]   next_pc,
  output logic [AW-1:0]   ret_addr
);

  localparam int HW = AW - JW;   // page bits that reach the address
  localparam int GW = JW - CW;   // zero gap between page and short target

  logic [HW-1:0] hi;
  assign hi = page[HW-1:0];

  generate
    if (PW > HW) begin : g_spare_page
      logic unused_page_hi;
      assign unused_page_hi = ^page[PW-1:HW];
    end
  endgenerate

  assign ret_addr = pc_q + AW'(1);

  always_comb begin
    unique case (op)
      OP_INC:  next_pc = pc_q + AW'(1);
      OP_JUMP: next_pc = {hi, imm};
      OP_CALL: next_pc = {hi, {GW{1'b0}}, imm[CW-1:0]};
      OP_PCW:  next_pc = {hi, {GW{1'b0}}, wdata};
      OP_RET:  next_pc = pop_addr;
      default: next_pc = pc_q;
    endcase
  end

endmodule

// File: rtl/fpc_stack.sv
module fpc_stack #(
  parameter int AW    = 11,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_data,
  output logic [AW-1:0] top_data,
  output logic          overflow,
  output logic          underflow
);

  localparam int NW = $clog2(DEPTH + 1);

  logic [AW-1:0] slot_q [DEPTH];
  logic [NW-1:0] cnt_q;
  logic          full;
  logic          empty;

  assign full      = (cnt_q == NW'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign top_data  = slot_q[0];
  assign overflow  = push & full;
  assign underflow = pop & empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else if (push) begin
      // shift toward the bottom; the deepest entry falls off when full
      slot_q[0] <= push_data;
      for (int i = 1; i < DEPTH; i++) slot_q[i] <= slot_q[i-1];
      if (!full) cnt_q <= cnt_q + NW'(1);
    end else if (pop) begin
      // shift only live entries up, so the last live one stays in place
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (NW'(i + 1) < cnt_q) slot_q[i] <= slot_q[i+1];
      end
      if (!empty) cnt_q <= cnt_q - NW'(1);
    end
  end

endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
  import fpc_pkg::*;
#(
  parameter int AW    = 11,
  parameter int PW    = 3,
  parameter int JW    = 9,
  parameter int CW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall,
  input  logic          jump_req,
  input  logic          call_req,
  input  logic          ret_req,
  input  logic          pcl_we,
  input  logic [JW-1:0] imm_addr,
  input  logic [PW-1:0] page_sel,
  input  logic [CW-1:0] pcl_wdata,
  output logic [AW-1:0] fetch_addr,
  output logic [CW-1:0] pcl_rdata,
  output logic          stack_fault
);

  fpc_op_e       op;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] next_pc;
  logic [AW-1:0] ret_addr;
  logic [AW-1:0] top_data;
  logic          ovf;
  logic          unf;
  logic          fault_q;

  fpc_decide u_decide (
    .stall    (stall),
    .ret_req  (ret_req),
    .call_req (call_req),
    .jump_req (jump_req),
    .pcl_we   (pcl_we),
    .op       (op)
  );

  fpc_target #(.AW(AW), .PW(PW), .JW(JW), .CW(CW)) u_target (
    .op       (op),
    .pc_q     (pc_q),
    .page     (page_sel),
    .imm      (imm_addr),
    .wdata    (pcl_wdata),
    .pop_addr (top_data),
    .next_pc  (next_pc),
    .ret_addr (ret_addr)
  );

  fpc_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (op == OP_CALL),
    .pop       (op == OP_RET),
    .push_data (ret_addr),
    .top_data  (top_data),
    .overflow  (ovf),
    .underflow (unf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '1;
      fault_q <= 1'b0;
    end else begin
      pc_q <= next_pc;
      if (ovf || unf) fault_q <= 1'b1;
    end
  end

  assign fetch_addr  = pc_q;
  assign pcl_rdata   = pc_q[CW-1:0];
  assign stack_fault = fault_q;

endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
  parameter int AW = 11,
  parameter int PW = 3,
  parameter int JW = 9,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          stall,
  input logic          jump_req,
  input logic          call_req,
  input logic          ret_req,
  input logic          pcl_we,
  input logic [JW-1:0] imm_addr,
  input logic [PW-1:0] page_sel,
  input logic [CW-1:0] pcl_wdata,
  input logic [AW-1:0] fetch_addr,
  input logic          stack_fault
);

  localparam int HW = AW - JW;
  localparam int GW = JW - CW;

  logic plain;
  assign plain = !stall && !ret_req && !call_req && !jump_req && !pcl_we;

  AST_RESET_TOP: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fetch_addr == {AW{1'b1}} && !stack_fault)); // R1

  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
    plain |=> fetch_addr == AW'($past(fetch_addr) + AW'(1))); // R2

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    (!stall && !ret_req && !call_req && jump_req)
      |=> fetch_addr == {$past(page_sel[HW-1:0]), $past(imm_addr)}); // R3

  AST_CALL_TARGET: assert property (@(posedge clk) disable iff (rst)
    (!stall && !ret_req && call_req)
      |=> fetch_addr == {$past(page_sel[HW-1:0]), {GW{1'b0}}, $past(imm_addr[CW-1:0])}); // R4

  AST_PCL_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!stall && !ret_req && !call_req && !jump_req && pcl_we)
      |=> fetch_addr == {$past(page_sel[HW-1:0]), {GW{1'b0}}, $past(pcl_wdata)}); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(fetch_addr) && $stable(stack_fault))); // R9

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(stack_fault)) |-> stack_fault); // R12

endmodule

bind fetch_pc_unit fpc_checker #(.AW(AW), .PW(PW), .JW(JW), .CW(CW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .stall       (stall),
  .jump_req    (jump_req),
  .call_req    (call_req),
  .ret_req     (ret_req),
  .pcl_we      (pcl_we),
  .imm_addr    (imm_addr),
  .page_sel    (page_sel),
  .pcl_wdata   (pcl_wdata),
  .fetch_addr  (fetch_addr),
  .stack_fault (stack_fault)
);

// File: tb/fetch_pc_unit_tb.sv
module fetch_pc_unit_tb;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst, stall, jump_req, call_req, ret_req, pcl_we;
  logic [8:0] imm_addr;
  logic [2:0] page_sel;
  logic [7:0] pcl_wdata;
  logic [10:0] fetch_addr;
  logic [7:0]  pcl_rdata;
  logic        stack_fault;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  // behavioural reference
  int m_pc;
  int m_q[$];
  int m_last;
  bit m_fault;

  always #(CLK_P/2) clk = ~clk;

  fetch_pc_unit u_dut (
    .clk(clk), .rst(rst), .stall(stall), .jump_req(jump_req),
    .call_req(call_req), .ret_req(ret_req), .pcl_we(pcl_we),
    .imm_addr(imm_addr), .page_sel(page_sel), .pcl_wdata(pcl_wdata),
    .fetch_addr(fetch_addr), .pcl_rdata(pcl_rdata), .stack_fault(stack_fault)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: apply inputs, advance model on the edge, compare after it
  task automatic cyc(input bit r, input bit s, input bit rt, input bit c,
                     input bit j, input bit w, input int imm, input int pg,
                     input int wd);
    string tag;
    int    nreq;
    int    hi;
    rst = r; stall = s; ret_req = rt; call_req = c; jump_req = j; pcl_we = w;
    imm_addr = imm[8:0]; page_sel = pg[2:0]; pcl_wdata = wd[7:0];
    @(posedge clk);
    nreq = int'(rt) + int'(c) + int'(j) + int'(w);
    hi   = (pg & 3) << 9;
    if (r) begin
      tag = "R1"; m_pc = 'h7FF; m_q.delete(); m_last = 0; m_fault = 0;
    end else if (s) begin
      tag = "R9";
    end else if (rt) begin
      if (m_q.size() > 0) begin
        tag = (nreq > 1) ? "R8" : "R5";
        m_last = m_q.pop_front();
      end else begin
        tag = "R11"; m_fault = 1;
      end
      m_pc = m_last;
    end else if (c) begin
      tag = (nreq > 1) ? "R8" : "R4";
      m_q.push_front((m_pc + 1) & 'h7FF);
      if (m_q.size() > 8) begin
        void'(m_q.pop_back()); m_fault = 1; tag = "R10";
      end
      m_pc = hi | (imm & 'hFF);
    end else if (j) begin
      tag = (nreq > 1) ? "R8" : "R3";
      m_pc = hi | (imm & 'h1FF);
    end else if (w) begin
      tag = "R7";
      m_pc = hi | (wd & 'hFF);
    end else begin
      tag = "R2";
      m_pc = (m_pc + 1) & 'h7FF;
    end
    #1;
    chk(tag, int'(fetch_addr), m_pc);
    chk("R6", int'(pcl_rdata), m_pc & 'hFF);
    chk("R12", int'(stack_fault), int'(m_fault));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; stall = 0; jump_req = 0; call_req = 0; ret_req = 0; pcl_we = 0;
    imm_addr = 0; page_sel = 0; pcl_wdata = 0;
    // R1: reset state
    for (int k = 0; k < 3; k++) cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R2: first step wraps 0x7FF -> 0x000
    idle(3);
    // R3: jump near top then wrap; page bit 2 ignored
    cyc(0, 0, 0, 0, 1, 0, 'h1FE, 7, 0);
    idle(3);
    // R2: crossing 0x1FF -> 0x200
    cyc(0, 0, 0, 0, 1, 0, 'h1FD, 4, 0);
    idle(4);
    // R4/R5: nested calls and returns
    cyc(0, 0, 0, 1, 0, 0, 'h1A5, 1, 0);
    idle(2);
    cyc(0, 0, 0, 1, 0, 0, 'h033, 2, 0);
    cyc(0, 0, 0, 1, 0, 0, 'h0FF, 3, 0);
    cyc(0, 0, 1, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 0, 0, 0, 0);
    idle(1);
    cyc(0, 0, 1, 0, 0, 0, 0, 0, 0);
    // R7: low-byte write
    cyc(0, 0, 0, 0, 0, 1, 0, 6, 'hC3);
    idle(2);
    // R9: stall with every request active
    cyc(0, 1, 1, 1, 1, 1, 'h155, 2, 'h77);
    cyc(0, 1, 0, 1, 0, 0, 'h011, 1, 0);
    idle(1);
    // R8: priority combinations
    cyc(0, 0, 0, 1, 1, 1, 'h1AA, 1, 'h11);
    cyc(0, 0, 0, 0, 1, 1, 'h0AA, 2, 'h22);
    cyc(0, 0, 1, 1, 1, 1, 'h055, 3, 'h33);
    idle(1);
    // R10: ten calls overflow, R11: eleven returns underflow
    for (int k = 0; k < 10; k++) cyc(0, 0, 0, 1, 0, 0, 16 * k + 5, k, 0);
    for (int k = 0; k < 11; k++) cyc(0, 0, 1, 0, 0, 0, 0, 0, 0);
    idle(2);
    // R12: fault survives calls, returns and stalls; cleared only by reset
    cyc(0, 1, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 'h010, 0, 0);
    cyc(0, 0, 1, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R11: pop after reset returns 0x000
    cyc(0, 0, 1, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
    // mixed random traffic
    for (int k = 0; k < 4000; k++) begin
      int sel;
      sel = $urandom_range(0, 99);
      cyc(sel == 0, sel < 8, (sel >= 8 && sel < 22) || sel == 90,
          (sel >= 22 && sel < 38) || sel == 90 || sel == 91,
          (sel >= 38 && sel < 46) || sel == 91 || sel == 92,
          (sel >= 46 && sel < 52) || sel == 92,
          $urandom_range(0, 511), $urandom_range(0, 7), $urandom_range(0, 255));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule